// File: doc/BRIEF.md
# Muon Track Crossing-Time Assigner

This block gives each muon track candidate a single bunch-crossing tag. Four detector stations each report at most one segment per crossing, as a valid bit together with the crossing index at which that segment arrived. The block runs at the 80 MHz crossing rate, a 12.5 ns period, and takes one set of station reports per clock.

The first valid segment that arrives while the block is idle opens a collection window three crossings long. Segments that arrive inside the window are merged into a station-hit mask. The track's crossing is the crossing in which the second distinct station arrived, so several stations reporting in one crossing count as arriving together. When the window closes the block applies an occupancy test. At least three of the four stations must have contributed, and if so the block emits a one-cycle track pulse with the assigned crossing and the mask. A window that fails the test emits nothing.

Top module: `muon_bx_assigner`

## Requirements
- R1: While the block is idle, the first crossing that has any bit of `seg_vld` set opens a window. The window covers that crossing and the next two crossings.
- R2: Bit i of `trk_mask` is set exactly when station i (`seg_vld[i]`) reported in at least one crossing of the window.
- R3: `trk_bx` is the crossing index of the crossing in which the number of distinct contributing stations first reaches two. Stations that report in the same crossing count as simultaneous. Station i's index is read from `seg_bx[i*8 +: 8]`, taking the lowest-numbered station that is new in that crossing.
- R4: `trk_vld` pulses only when at least three distinct stations contributed. A window with fewer than three produces no pulse.
- R5: A second report from a station already in the open window is ignored. It changes neither the mask nor the arrival order.
- R6: The decision for a window appears on the outputs right after the third rising edge that follows the edge which sampled the opening crossing. `trk_vld` is high for exactly one cycle, and `trk_bx` and `trk_mask` read zero whenever `trk_vld` is low.
- R7: A segment in the crossing right after a window's last crossing opens a new window with that crossing as its first. No crossing is lost between back-to-back windows.
- R8: A synchronous reset (`rst` high) closes any open window, cancels any pending decision and drives all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock (80 MHz in the system) |
| rst | input | 1 | Synchronous reset, active high |
| seg_vld | input | 4 | Per-station segment valid, bit i = station i |
| seg_bx | input | 32 | Per-station arrival crossing index, 8 bits per station, station i at bits i*8+7..i*8 |
| trk_vld | output | 1 | One-cycle pulse for an accepted track |
| trk_bx | output | 8 | Assigned crossing of the accepted track |
| trk_mask | output | 4 | Stations that contributed to the accepted track |

## Verification
The assertions take for granted that reset is applied before the first report. They also assume that all stations reporting in one crossing present the same crossing index, and that this index advances by one from each crossing to the next. The stimulus keeps to this by driving every station's index from one shared counter that steps once per clock. Random valid patterns come from a fixed seed and include sparse, dense and repeated reports. Directed cases cover simultaneous arrival, repeats, rejected windows, back-to-back windows and a reset that lands inside a window.

// File: rtl/muon_bx_assigner.sv
module muon_bx_assigner #(
  parameter int N_ST     = 4,
  parameter int BXW      = 8,
  parameter int WIN      = 3,
  parameter int ORDER    = 2,
  parameter int MIN_HITS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_ST-1:0]     seg_vld,
  input  logic [N_ST*BXW-1:0] seg_bx,
  output logic                trk_vld,
  output logic [BXW-1:0]      trk_bx,
  output logic [N_ST-1:0]     trk_mask
);

  localparam int PW = $clog2(WIN + 1);
  localparam int CW = $clog2(N_ST + 1);

  function automatic logic [CW-1:0] popc(input logic [N_ST-1:0] m);
    logic [CW-1:0] s;
    s = '0;
    for (int i = 0; i < N_ST; i++) s = s + CW'(m[i]);
    return s;
  endfunction

  logic            win_open, dec_pend;
  logic [PW-1:0]   pos;
  logic [N_ST-1:0] acc_mask;
  logic [BXW-1:0]  acc_bx;

  logic [N_ST-1:0] base_mask, fresh, nxt_mask;
  logic [BXW-1:0]  fresh_bx, nxt_bx;
  logic            crossed, last, accept;

  assign base_mask = win_open ? acc_mask : '0;
  assign fresh     = seg_vld & ~base_mask;
  assign nxt_mask  = base_mask | fresh;
  assign crossed   = (popc(base_mask) < CW'(ORDER)) && (popc(nxt_mask) >= CW'(ORDER));
  assign nxt_bx    = crossed ? fresh_bx : (win_open ? acc_bx : '0);
  assign last      = win_open && (pos == PW'(WIN - 1));
  assign accept    = dec_pend && (popc(acc_mask) >= CW'(MIN_HITS));

  always_comb begin
    fresh_bx = '0;
    for (int i = N_ST - 1; i >= 0; i--)
      if (fresh[i]) fresh_bx = seg_bx[i*BXW +: BXW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_open <= 1'b0;
      dec_pend <= 1'b0;
      pos      <= '0;
      acc_mask <= '0;
      acc_bx   <= '0;
      trk_vld  <= 1'b0;
      trk_bx   <= '0;
      trk_mask <= '0;
    end else begin
      trk_vld  <= accept;
      trk_bx   <= accept ? acc_bx : '0;
      trk_mask <= accept ? acc_mask : '0;
      if (win_open || (|seg_vld)) begin
        acc_mask <= nxt_mask;
        acc_bx   <= nxt_bx;
      end
      if (!win_open) begin
        dec_pend <= 1'b0;
        if (|seg_vld) begin
          win_open <= 1'b1;
          pos      <= PW'(1);
        end
      end else begin
        pos      <= pos + PW'(1);
        dec_pend <= last;
        if (last) win_open <= 1'b0;
      end
    end
  end

  a_r4_enough_hits: assert property (@(posedge clk) disable iff (rst)
    trk_vld |-> ($countones(trk_mask) >= MIN_HITS));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    trk_vld |=> !trk_vld);

  a_r6_quiet_outputs: assert property (@(posedge clk) disable iff (rst)
    !trk_vld |-> (trk_bx == '0 && trk_mask == '0));

  a_r6_close_at_end: assert property (@(posedge clk) disable iff (rst)
    (win_open && pos == PW'(WIN - 1)) |=> (!win_open && dec_pend));

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (!trk_vld && !win_open && !dec_pend));

endmodule

// File: tb/muon_bx_assigner_tb.sv
module muon_bx_assigner_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  seg_vld;
  logic [31:0] seg_bx;
  logic        trk_vld;
  logic [7:0]  trk_bx;
  logic [3:0]  trk_mask;

  int checks = 0, failures = 0;
  logic [7:0] cur = 8'd0;

  logic m_open, m_pend;
  int   m_pos;
  logic [3:0] m_mask;
  logic [7:0] m_sec;
  logic e_vld;
  logic [7:0] e_bx;
  logic [3:0] e_mask;

  always #2 clk = ~clk;

  muon_bx_assigner u_dut (
    .clk(clk), .rst(rst), .seg_vld(seg_vld), .seg_bx(seg_bx),
    .trk_vld(trk_vld), .trk_bx(trk_bx), .trk_mask(trk_mask)
  );

  task automatic mdl(input logic [3:0] v, input logic [7:0] bx, input logic r);
    int old;
    if (r) begin
      m_open = 0; m_pend = 0; m_pos = 0; m_mask = 0; m_sec = 0;
      e_vld = 0; e_bx = 0; e_mask = 0;
    end else begin
      e_vld  = m_pend && ($countones(m_mask) >= 3);
      e_bx   = e_vld ? m_sec : 8'd0;
      e_mask = e_vld ? m_mask : 4'd0;
      if (!m_open) begin
        m_pend = 0;
        if (v != 0) begin
          m_open = 1; m_pos = 1; m_mask = v;
          m_sec = ($countones(v) >= 2) ? bx : 8'd0;
        end
      end else begin
        old = $countones(m_mask);
        m_mask = m_mask | v;
        if (old < 2 && $countones(m_mask) >= 2) m_sec = bx;
        m_pos++;
        m_pend = 0;
        if (m_pos == 3) begin m_open = 0; m_pend = 1; end
      end
    end
  endtask

  task automatic cyc(input logic [3:0] v, input logic r, input string tag);
    seg_vld = v;
    rst = r;
    seg_bx = {4{cur}};
    @(posedge clk);
    #1 mdl(v, cur, r);
    cur = cur + 8'd1;
    @(negedge clk);
    checks++;
    if (trk_vld !== e_vld || trk_bx !== e_bx || trk_mask !== e_mask) begin
      failures++;
      $display("FAIL %s: got vld=%0b bx=%0d mask=%b exp vld=%0b bx=%0d mask=%b",
               tag, trk_vld, trk_bx, trk_mask, e_vld, e_bx, e_mask);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(4'b0000, 1'b0, tag);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog: got hang exp finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    logic [3:0] v;
    seed = $urandom(32'h5EED_0042);
    seg_vld = 0; seg_bx = 0; rst = 1;
    @(negedge clk);
    cyc(4'b0000, 1'b1, "R8");
    cyc(4'b1111, 1'b1, "R8");
    idle(2, "R8");
    // R3 R6: second arrival in the middle crossing
    cyc(4'b0001, 1'b0, "R1"); cyc(4'b0110, 1'b0, "R3"); cyc(4'b0000, 1'b0, "R3");
    idle(3, "R6");
    // R3: three stations simultaneous in the opening crossing
    cyc(4'b1011, 1'b0, "R3"); idle(5, "R3");
    // R4: only two stations, no pulse
    cyc(4'b0001, 1'b0, "R4"); cyc(4'b0000, 1'b0, "R4"); cyc(4'b0010, 1'b0, "R4");
    idle(4, "R4");
    // R5: repeat from station 0 is ignored for arrival order
    cyc(4'b0001, 1'b0, "R5"); cyc(4'b0001, 1'b0, "R5"); cyc(4'b0110, 1'b0, "R5");
    idle(4, "R5");
    // R7: back-to-back windows
    cyc(4'b0001, 1'b0, "R7"); cyc(4'b0010, 1'b0, "R7"); cyc(4'b0100, 1'b0, "R7");
    cyc(4'b1111, 1'b0, "R7"); cyc(4'b0000, 1'b0, "R7"); cyc(4'b0000, 1'b0, "R7");
    idle(4, "R7");
    // R2: last crossing alone brings the third station
    cyc(4'b1000, 1'b0, "R2"); cyc(4'b0000, 1'b0, "R2"); cyc(4'b0101, 1'b0, "R2");
    idle(4, "R2");
    // R8: reset inside a window drops it
    cyc(4'b0011, 1'b0, "R8"); cyc(4'b0100, 1'b1, "R8"); cyc(4'b0000, 1'b0, "R8");
    idle(4, "R8");
    // R8: reset on the cycle the decision is pending
    cyc(4'b0111, 1'b0, "R8"); cyc(4'b0000, 1'b0, "R8"); cyc(4'b0000, 1'b0, "R8");
    cyc(4'b0000, 1'b1, "R8"); idle(3, "R8");
    for (int i = 0; i < 4000; i++) begin
      case ($urandom % 4)
        0: v = 4'b0000;
        1: v = 4'($urandom) & 4'($urandom);
        2: v = 4'($urandom);
        default: v = 4'($urandom) | 4'($urandom);
      endcase
      cyc(v, ($urandom % 500) == 0, "R2");
    end
    idle(4, "R6");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule